// File: doc/BRIEF.md
# Indirect Dword Register Window

This block lets configuration software reach a larger working register file through an 8-byte window held in configuration space. The window has two writable fields. A select byte picks one dword of the working file. A 32-bit data register mirrors the selected dword. When software writes the data register, the block passes the value on as a full-dword write to the selected dword. After every write that touches the window, the data register is reloaded from the working file, so a following read sees the value the file actually holds after its write masks were applied.

The working file supplies, for the addressed dword, its current contents and two per-byte masks: a write-enable mask and a write-one-to-clear mask. The block merges the forwarded value against these masks and drives a full-dword write back. The file holds 36 bytes plus 4 bytes per slot. Any dword that starts at or beyond the end of the file is neither written nor read: reads there return zero. The working-file address is as wide as the file size rounded up to the next power of two.

A forwarded write that lands on the dword holding the command bytes (working offsets 0x14 to 0x15) raises a one-cycle command strobe on the cycle after the write.

Top module: `iw_window`

## Requirements
- R1: After reset the select byte and the data register both read as zero, and no working write or command strobe is issued.
- R2: A configuration write to the window's first dword with byte-enable bit 2 set loads the select byte from write-data bits 23:16. The next read of that dword shows the select value in bits 23:16.
- R3: A configuration write to the window's second dword updates the enabled bytes of the data register. In the same cycle it issues a working write to byte address select×4. Each byte of that write is (old AND NOT wmask) OR (value AND wmask).
- R4: Each byte of the forwarded write is then cleared wherever the value AND the write-one-to-clear mask is 1.
- R5: On the clock edge after any write that hits either window dword, the data register is reloaded from working address select×4. This also happens when the write enabled none of the select or data bytes.
- R6: Configuration writes to any other dword leave the select, the data register and the working file unchanged.
- R7: When select×4 is at or above the file size (36 + 4×SLOTS bytes), no working write is issued and the reload yields zero.
- R8: A forwarded working write to byte address 0x14 (the dword covering offsets 0x14 to 0x15) raises cmd_strobe_o for exactly the following cycle. Writes to other dwords do not raise it.
- R9: A data write in the same cycle as a pending reload merges its enabled bytes over the freshly read working dword, not over the stale register value. A reload follows it.
- R10: Bits 31:24 of the window's first dword (pending-status bits) always read as zero and ignore writes. Bits 15:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_waddr_i | input | CFG_AW | Configuration write dword address |
| cfg_be_i | input | 4 | Configuration write byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_raddr_i | input | CFG_AW | Configuration read dword address |
| cfg_rdata_o | output | 32 | Window read data (zero outside the window) |
| wf_we_o | output | 1 | Working-file dword write strobe |
| wf_addr_o | output | WF_AW | Working-file byte address (select×4, truncated to the aperture) |
| wf_wdata_o | output | 32 | Masked and merged working-file write data |
| wf_rdata_i | input | 32 | Working-file dword at wf_addr_o |
| wf_wmask_i | input | 32 | Per-bit write-enable mask of that dword |
| wf_w1c_i | input | 32 | Per-bit write-one-to-clear mask of that dword |
| cmd_strobe_o | output | 1 | One-cycle pulse after a write to the command dword |

## Verification
A data-register write can arrive in the very cycle in which the reload from the previous window write is still pending. The merge base and the register update then come from two different sources in one cycle. The bench provokes this by issuing a select write and a partial-byte data write on back-to-back cycles, and by back-to-back data writes. It judges the result by comparing the data register, on every cycle, with a reference model built from the requirements. It also checks the merged dword against hand-computed bytes, which differ from what a stale merge base would give.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int unsigned HDR_BYTES  = 36;
  localparam int unsigned CMD_BYTE   = 32'h14;
  localparam int unsigned SEL_W      = 8;

  function automatic int unsigned file_bytes(input int unsigned slots);
    return HDR_BYTES + 4 * slots;
  endfunction

  // smallest power of two strictly above x
  function automatic int unsigned pow2_above(input int unsigned x);
    int unsigned r;
    r = 1;
    while (r <= x) r = r << 1;
    return r;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  typedef struct packed {
    logic        hit_cap;
    logic        hit_sel;
    logic        hit_data;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_wr_t;
endpackage

// File: rtl/iw_cfg_decode.sv
module iw_cfg_decode import iw_pkg::*; #(
  parameter int unsigned CFG_AW = 6,
  parameter logic [CFG_AW-1:0] CAP_DW = '0
) (
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_waddr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output cfg_wr_t           dec_o
);
  localparam logic [CFG_AW-1:0] DATA_DW = CAP_DW + CFG_AW'(1);

  logic at_hdr, at_data;

  always_comb begin
    at_hdr         = cfg_waddr_i == CAP_DW;
    at_data        = cfg_waddr_i == DATA_DW;
    dec_o.hit_cap  = cfg_we_i && (at_hdr || at_data);
    dec_o.hit_sel  = cfg_we_i && at_hdr && cfg_be_i[2];
    dec_o.hit_data = cfg_we_i && at_data;
    dec_o.be       = cfg_be_i;
    dec_o.wdata    = cfg_wdata_i;
  end
endmodule

// File: rtl/iw_cap_regs.sv
module iw_cap_regs import iw_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_wr_t          dec_i,
  input  logic [31:0]      rd_word_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [31:0]      data_o,
  output logic             refresh_o,
  output logic [31:0]      fwd_val_o
);
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      data_q;
  logic             refresh_q;
  logic [31:0]      base;

  // a pending reload supplies the merge base, not the stale register
  always_comb begin
    base      = refresh_q ? rd_word_i : data_q;
    fwd_val_o = be_merge(base, dec_i.wdata, dec_i.be);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      data_q    <= '0;
      refresh_q <= 1'b0;
    end else begin
      if (dec_i.hit_sel)  sel_q <= dec_i.wdata[23:16];
      if (dec_i.hit_data) data_q <= fwd_val_o;
      else if (refresh_q) data_q <= rd_word_i;
      refresh_q <= dec_i.hit_cap;
    end
  end

  assign sel_o     = sel_q;
  assign data_o    = data_q;
  assign refresh_o = refresh_q;
endmodule

// File: rtl/iw_wr_merge.sv
module iw_wr_merge import iw_pkg::*; #(
  parameter int unsigned FILE_BYTES = 160,
  parameter int unsigned WF_AW      = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fwd_i,
  input  logic [31:0]      fwd_val_i,
  input  logic [31:0]      wf_rdata_i,
  input  logic [31:0]      wf_wmask_i,
  input  logic [31:0]      wf_w1c_i,
  output logic [31:0]      rd_word_o,
  output logic             wf_we_o,
  output logic [WF_AW-1:0] wf_addr_o,
  output logic [31:0]      wf_wdata_o
);
  localparam int unsigned BA_W = SEL_W + 2;

  logic [BA_W-1:0] byte_addr;
  logic            in_range;

  always_comb begin
    byte_addr = {sel_i, 2'b00};
    in_range  = 32'(byte_addr) < FILE_BYTES;
  end

  for (genvar b = 0; b < 4; b++) begin : g_byte
    logic [7:0] old_b, val_b, wm_b, wc_b;
    always_comb begin
      old_b = wf_rdata_i[8*b +: 8];
      val_b = fwd_val_i[8*b +: 8];
      wm_b  = wf_wmask_i[8*b +: 8];
      wc_b  = wf_w1c_i[8*b +: 8];
      wf_wdata_o[8*b +: 8] = ((old_b & ~wm_b) | (val_b & wm_b)) & ~(val_b & wc_b);
    end
  end

  assign rd_word_o = in_range ? wf_rdata_i : 32'h0;
  assign wf_we_o   = fwd_i && in_range;
  assign wf_addr_o = byte_addr[WF_AW-1:0];
endmodule

// File: rtl/iw_window.sv
module iw_window import iw_pkg::*; #(
  parameter int unsigned SLOTS      = 31,
  parameter int unsigned CFG_AW     = 6,
  parameter int unsigned CAP_OFFSET = 32'h48,
  localparam int unsigned FILE_BYTES = file_bytes(SLOTS),
  localparam int unsigned APERTURE   = pow2_above(FILE_BYTES),
  localparam int unsigned WF_AW      = $clog2(APERTURE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_waddr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [CFG_AW-1:0] cfg_raddr_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              wf_we_o,
  output logic [WF_AW-1:0]  wf_addr_o,
  output logic [31:0]       wf_wdata_o,
  input  logic [31:0]       wf_rdata_i,
  input  logic [31:0]       wf_wmask_i,
  input  logic [31:0]       wf_w1c_i,
  output logic              cmd_strobe_o
);
  localparam logic [CFG_AW-1:0] CAP_DW  = CFG_AW'(CAP_OFFSET / 4);
  localparam logic [CFG_AW-1:0] DATA_DW = CAP_DW + CFG_AW'(1);

  cfg_wr_t          dec;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      data_q;
  logic             refresh_q;
  logic [31:0]      fwd_val;
  logic [31:0]      rd_word;
  logic             cmd_q;

  iw_cfg_decode #(.CFG_AW(CFG_AW), .CAP_DW(CAP_DW)) u_dec (
    .cfg_we_i   (cfg_we_i),
    .cfg_waddr_i(cfg_waddr_i),
    .cfg_be_i   (cfg_be_i),
    .cfg_wdata_i(cfg_wdata_i),
    .dec_o      (dec)
  );

  iw_cap_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec),
    .rd_word_i(rd_word),
    .sel_o    (sel_q),
    .data_o   (data_q),
    .refresh_o(refresh_q),
    .fwd_val_o(fwd_val)
  );

  iw_wr_merge #(.FILE_BYTES(FILE_BYTES), .WF_AW(WF_AW)) u_merge (
    .sel_i     (sel_q),
    .fwd_i     (dec.hit_data),
    .fwd_val_i (fwd_val),
    .wf_rdata_i(wf_rdata_i),
    .wf_wmask_i(wf_wmask_i),
    .wf_w1c_i  (wf_w1c_i),
    .rd_word_o (rd_word),
    .wf_we_o   (wf_we_o),
    .wf_addr_o (wf_addr_o),
    .wf_wdata_o(wf_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 1'b0;
    else         cmd_q <= wf_we_o && ({sel_q, 2'b00} == (SEL_W+2)'(CMD_BYTE));
  end
  assign cmd_strobe_o = cmd_q;

  always_comb begin
    if (cfg_raddr_i == CAP_DW)       cfg_rdata_o = {8'h00, sel_q, 16'h0000};
    else if (cfg_raddr_i == DATA_DW) cfg_rdata_o = data_q;
    else                             cfg_rdata_o = 32'h0;
  end
endmodule

// File: rtl/iw_window_chk.sv
module iw_window_chk #(
  parameter int unsigned CFG_AW     = 6,
  parameter int unsigned CAP_DW     = 18,
  parameter int unsigned FILE_BYTES = 160,
  parameter int unsigned WF_AW      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_waddr_i,
  input logic [3:0]        cfg_be_i,
  input logic [31:0]       cfg_wdata_i,
  input logic [CFG_AW-1:0] cfg_raddr_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              wf_we_o,
  input logic [WF_AW-1:0]  wf_addr_o,
  input logic              cmd_strobe_o,
  input logic [7:0]        sel_q,
  input logic [31:0]       data_q,
  input logic [31:0]       rd_word,
  input logic              refresh_q
);
  logic hdr_wr, dat_wr, cap_wr;
  assign hdr_wr = cfg_we_i && (32'(cfg_waddr_i) == CAP_DW);
  assign dat_wr = cfg_we_i && (32'(cfg_waddr_i) == CAP_DW + 1);
  assign cap_wr = hdr_wr || dat_wr;

  a_r2_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_wr && cfg_be_i[2] |=> sel_q == $past(cfg_wdata_i[23:16]));

  a_r3_wr_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wf_we_o |-> dat_wr && (32'(wf_addr_o) == 32'(sel_q) * 4 % (1 << WF_AW)));

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_q && !dat_wr |=> data_q == $past(rd_word));

  a_r5_reload_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_wr |=> refresh_q);

  a_r6_ignore_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_wr && !refresh_q |=> $stable(data_q) && $stable(sel_q));

  a_r7_no_oob_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_q) * 4 >= FILE_BYTES |-> !wf_we_o && rd_word == 32'h0);

  a_r8_strobe_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |-> $past(wf_we_o) && ($past(32'(sel_q)) == 5));

  a_r8_strobe_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wf_we_o && (32'(sel_q) == 5) |=> cmd_strobe_o);

  a_r10_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cfg_raddr_i) == CAP_DW) |-> cfg_rdata_o[31:24] == 8'h00 && cfg_rdata_o[15:0] == 16'h0);
endmodule

bind iw_window iw_window_chk #(
  .CFG_AW(CFG_AW), .CAP_DW(CAP_OFFSET / 4), .FILE_BYTES(FILE_BYTES), .WF_AW(WF_AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_waddr_i),
  .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_raddr_i(cfg_raddr_i),
  .cfg_rdata_o(cfg_rdata_o), .wf_we_o(wf_we_o), .wf_addr_o(wf_addr_o),
  .cmd_strobe_o(cmd_strobe_o), .sel_q(sel_q), .data_q(data_q), .rd_word(rd_word),
  .refresh_q(refresh_q)
);

// File: tb/iw_window_test.sv
module iw_window_test;
  localparam int PERIOD  = 10;
  localparam int SLOTS   = 31;
  localparam int CFG_AW  = 6;
  localparam int CAP_OFF = 'h48;
  localparam int CAP_DW  = CAP_OFF / 4;
  localparam int FBYTES  = 36 + 4 * SLOTS;   // 160
  localparam int APER    = 256;
  localparam int WF_AW   = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CFG_AW-1:0] cfg_waddr = 0, cfg_raddr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata, wf_wdata, wf_rdata, wf_wmask, wf_w1c;
  logic wf_we, cmd_strobe;
  logic [WF_AW-1:0] wf_addr;

  int checks = 0, fails = 0;
  logic [7:0] mem [APER];
  logic [7:0] exp_mem [APER];
  logic [7:0] m_sel = 0;
  logic [31:0] m_data = 0;
  logic m_ref = 0, m_strobe = 0;

  always #(PERIOD/2) clk = ~clk;

  iw_window #(.SLOTS(SLOTS), .CFG_AW(CFG_AW), .CAP_OFFSET(CAP_OFF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_waddr_i(cfg_waddr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_raddr_i(cfg_raddr),
    .cfg_rdata_o(cfg_rdata), .wf_we_o(wf_we), .wf_addr_o(wf_addr),
    .wf_wdata_o(wf_wdata), .wf_rdata_i(wf_rdata), .wf_wmask_i(wf_wmask),
    .wf_w1c_i(wf_w1c), .cmd_strobe_o(cmd_strobe));

  function automatic logic [7:0] init_b(int i); return 8'(i * 37 + 91); endfunction
  function automatic logic [7:0] wm_b(int i);
    case ((i % 16) / 4)
      0: return 8'hFF; 1: return 8'h0F; 2: return 8'h00; default: return 8'hF0;
    endcase
  endfunction
  function automatic logic [7:0] wc_b(int i);
    case ((i % 16) / 4)
      1: return 8'h30; 2: return 8'h3C; default: return 8'h00;
    endcase
  endfunction
  function automatic logic [31:0] exp_word(int a);
    return {exp_mem[a+3], exp_mem[a+2], exp_mem[a+1], exp_mem[a]};
  endfunction

  // behavioural working file
  assign wf_rdata = {mem[int'(wf_addr)+3], mem[int'(wf_addr)+2], mem[int'(wf_addr)+1], mem[int'(wf_addr)]};
  assign wf_wmask = {wm_b(int'(wf_addr)+3), wm_b(int'(wf_addr)+2), wm_b(int'(wf_addr)+1), wm_b(int'(wf_addr))};
  assign wf_w1c   = {wc_b(int'(wf_addr)+3), wc_b(int'(wf_addr)+2), wc_b(int'(wf_addr)+1), wc_b(int'(wf_addr))};
  always @(posedge clk)
    if (wf_we) for (int k = 0; k < 4; k++) mem[int'(wf_addr)+k] <= wf_wdata[8*k +: 8];

  // reference model
  always @(posedge clk) begin
    if (rst_n) begin
      automatic logic [31:0] rd, base, nd, fv;
      automatic logic [7:0] ns = m_sel;
      automatic logic nref = 0, nstr = 0;
      automatic int a = int'(m_sel) * 4;
      rd   = (a < FBYTES) ? exp_word(a) : 32'h0;
      base = m_ref ? rd : m_data;
      nd   = base;
      if (cfg_we && int'(cfg_waddr) == CAP_DW) begin
        if (cfg_be[2]) ns = cfg_wdata[23:16];
        nref = 1;
      end else if (cfg_we && int'(cfg_waddr) == CAP_DW + 1) begin
        for (int k = 0; k < 4; k++) fv[8*k +: 8] = cfg_be[k] ? cfg_wdata[8*k +: 8] : base[8*k +: 8];
        nd = fv; nref = 1;
        if (a < FBYTES) begin
          for (int k = 0; k < 4; k++) begin
            automatic logic [7:0] v = fv[8*k +: 8];
            exp_mem[a+k] = ((exp_mem[a+k] & ~wm_b(a+k)) | (v & wm_b(a+k))) & ~(v & wc_b(a+k));
          end
          nstr = (a == 'h14);
        end
      end
      m_sel = ns; m_data = nd; m_ref = nref; m_strobe = nstr;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  task automatic compare();
    automatic int a = int'(m_sel) * 4;
    automatic logic exp_we = cfg_we && int'(cfg_waddr) == CAP_DW + 1 && a < FBYTES;
    if (int'(cfg_raddr) == CAP_DW) chk("R2/R10 select dword", cfg_rdata, {8'h0, m_sel, 16'h0});
    else chk("R5/R9 data register", cfg_rdata, m_data);
    chk("R8 command strobe", 32'(cmd_strobe), 32'(m_strobe));
    chk("R3/R7 working write enable", 32'(wf_we), 32'(exp_we));
    if (exp_we) chk("R3 working address", 32'(wf_addr), 32'(a % APER));
  endtask

  task automatic cyc(bit we, int dw, logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    cfg_we = we; cfg_waddr = CFG_AW'(dw); cfg_be = be; cfg_wdata = wd;
    cfg_raddr = (cfg_raddr == CFG_AW'(CAP_DW)) ? CFG_AW'(CAP_DW + 1) : CFG_AW'(CAP_DW);
    #1 compare();
  endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0); endtask
  task automatic set_sel(int s); cyc(1, CAP_DW, 4'b0100, {8'h0, 8'(s), 16'h0}); idle(2); endtask
  task automatic wr_data(logic [3:0] be, logic [31:0] d); cyc(1, CAP_DW + 1, be, d); idle(2); endtask
  task automatic read_data(output logic [31:0] v);
    @(negedge clk); cfg_we = 0; cfg_raddr = CFG_AW'(CAP_DW + 1); #1 v = cfg_rdata;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < APER; i++) begin mem[i] = init_b(i); exp_mem[i] = init_b(i); end
    repeat (3) @(negedge clk);
    cfg_raddr = CFG_AW'(CAP_DW); #1 chk("R1 reset select", cfg_rdata, 32'h0);
    cfg_raddr = CFG_AW'(CAP_DW + 1); #1 chk("R1 reset data", cfg_rdata, 32'h0);
    chk("R1 reset strobe/we", {31'h0, cmd_strobe | wf_we}, 32'h0);
    @(negedge clk); rst_n = 1;
    idle(2);

    set_sel(3);
    read_data(v);
    chk("R5 reload after select", v, {init_b(15), init_b(14), init_b(13), init_b(12)});
    wr_data(4'hF, 32'hFFFF_FFFF);
    chk("R3 masked merge", {24'h0, mem[12]}, {24'h0, (init_b(12) & 8'h0F) | 8'hF0});

    set_sel(2);
    wr_data(4'hF, 32'h3C3C_3C3C);
    chk("R4 write-one-to-clear", {24'h0, mem[9]}, {24'h0, init_b(9) & 8'hC3});

    // file changes behind the window; a header write without the select byte reloads
    @(negedge clk); mem[8] = 8'h5A; exp_mem[8] = 8'h5A;
    cyc(1, CAP_DW, 4'b0001, 32'hFFFF_FFFF); idle(2);
    read_data(v); chk("R5 reload on byte-0 header write", {24'h0, v[7:0]}, 32'h5A);

    @(negedge clk); mem[9] = 8'h11; exp_mem[9] = 8'h11;
    cyc(1, 3, 4'hF, 32'hDEAD_BEEF); cyc(1, CAP_DW + 2, 4'hF, 32'h1234_5678); idle(2);
    read_data(v); chk("R6 foreign writes ignored", {24'h0, v[15:8]}, {24'h0, init_b(9) & 8'hC3});

    set_sel(4); wr_data(4'hF, 32'h0);
    set_sel(5); cyc(1, CAP_DW + 1, 4'hF, 32'h0000_00FF);
    @(negedge clk); cfg_we = 0; #1 chk("R8 strobe after command dword write", 32'(cmd_strobe), 1);
    @(negedge clk); #1 chk("R8 strobe lasts one cycle", 32'(cmd_strobe), 0);

    set_sel(39); wr_data(4'hF, 32'hA5A5_A5A5);
    read_data(v); chk("R3 last in-range dword", {24'h0, v[7:0]}, {24'h0, exp_mem[156]});
    set_sel(40); wr_data(4'hF, 32'hFFFF_FFFF);
    read_data(v); chk("R7 out-of-range reload is zero", v, 32'h0);
    set_sel(100); wr_data(4'hF, 32'hFFFF_FFFF);
    chk("R7 no aliased write", {24'h0, mem[144]}, {24'h0, init_b(144)});

    // reload and data write in the same cycle
    cyc(1, CAP_DW, 4'b0100, 32'h0006_0000);
    cyc(1, CAP_DW + 1, 4'b0001, 32'h0000_00AA);
    idle(2);
    read_data(v);
    chk("R9 merge over fresh dword", v, {init_b(27) & 8'hC3, init_b(26) & 8'hC3,
                                          init_b(25) & 8'hC3, init_b(24) & ~8'h28});
    cyc(1, CAP_DW + 1, 4'b0010, 32'h0000_FF00); cyc(1, CAP_DW + 1, 4'b1000, 32'h7700_0000); idle(2);

    cyc(1, CAP_DW, 4'b1011, 32'hFFFF_FFFF); idle(1);
    cfg_raddr = CFG_AW'(CAP_DW); #1 chk("R10 status byte reads zero", cfg_rdata, 32'h0006_0000);

    for (int s = 0; s < 42; s++) begin
      cyc(1, CAP_DW, 4'b0100, {8'h0, 8'(s), 16'h0});
      cyc(1, CAP_DW + 1, 4'(s % 15 + 1), 32'(s * 32'h0101_0101) ^ 32'hC33C_5AA5);
      idle(1);
    end
    idle(2);
    for (int i = 0; i < APER; i++) chk("R3/R4/R7 file contents", {24'h0, mem[i]}, {24'h0, exp_mem[i]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule